// File: doc/BRIEF.md
# Receive DMA Descriptor Chaining Engine

This engine takes the words of received packets from a per-channel receive FIFO and stores them in host memory buffers. The buffers come from a free ring that the host fills. Each free entry names a data buffer and a packet descriptor slot. A buffer is closed when its byte count reaches the size that the channel's buffer policy picks for it. The engine then fetches the next free entry and writes the closed buffer's descriptor, with a pointer to the new descriptor, so the buffers of one packet form a linked list.

The engine posts a done-ring entry when the packet ends, or earlier once a per-channel number of buffers has been filled. The entry points the host at the head of the descriptor chain. Only one packet is handled at a time. The channel of its first word selects the configuration. When the free ring is empty, the engine holds off the FIFO and raises a starvation flag.

Top module: `rxdma_chain_engine`

## Requirements
- R1: After reset, fifo_ready, mem_req and starve are low, and fq_rd_idx and dq_wr_idx are 0.
- R2: Each buffer is obtained by two reads at fq_base + 8*fq_rd_idx: the word at +0 is the data buffer address and the word at +4 is the packet descriptor address. fq_rd_idx then advances by one and wraps to 0 after fq_size-1.
- R3: Accepted FIFO words are written in arrival order to consecutive word addresses, starting at the start address of the current buffer.
- R4: The per-channel mode field (2 bits) selects the buffer size. Value 0 gives large_size for every buffer. Value 1 gives small_size for every buffer. Value 2 gives small_size for the first buffer of the packet and large_size for every later one. Value 3 acts as 0.
- R5: When a buffer is full and the segment goes on, the engine first fetches the next free entry. It then writes the full buffer's descriptor: +0 holds the buffer start address, +4 holds the newly fetched descriptor address, and +8 holds the byte count in bits 15:0 with bits 17:16 clear.
- R6: The last descriptor of a segment has a next pointer of 0 and bit 17 (last buffer) set. Bit 16 (end of packet) is set when the packet ended in that buffer. Its byte count adds fifo_nbytes (1 to 4) for each word, so a partial final word counts only its valid bytes.
- R7: A done entry is written at dq_base + 8*dq_wr_idx. Word +0 holds the head descriptor address of the segment. Word +4 holds the number of buffers in the segment in bits 2:0 and end of packet in bit 8. dq_wr_idx then advances modulo dq_size.
- R8: When the per-channel threshold (3 bits, 1 to 7) of filled buffers is reached without end of packet, a done entry with bit 8 clear is posted. The rest of the packet then starts a new segment and a new chain.
- R9: While a buffer is needed and fq_rd_idx equals fq_wr_idx, starve is high and fifo_ready is low. Both stay that way until the host moves fq_wr_idx.
- R10: A memory request keeps its address and direction unchanged until mem_ack, and every address is word aligned.
- R11: The mode and threshold in use are those of the channel (fifo_ch) that was presented with the first word of the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_req | input | 1 | FIFO presents a word |
| fifo_ch | input | CHW | Channel of the presented word |
| fifo_data | input | 32 | Data word |
| fifo_nbytes | input | 3 | Valid bytes in the word, 1 to 4 |
| fifo_eop | input | 1 | Word ends the packet |
| fifo_ready | output | 1 | Word is taken at this clock edge when fifo_req is high |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completed |
| cfg_mode | input | 2*NCH | Buffer policy per channel |
| cfg_thr | input | 3*NCH | Buffers per done entry per channel |
| small_size | input | SZW | Small buffer size in bytes, a multiple of 4 |
| large_size | input | SZW | Large buffer size in bytes, a multiple of 4 |
| fq_base | input | 32 | Free ring base address |
| fq_size | input | IDXW | Free ring entries |
| fq_wr_idx | input | IDXW | Host write index of the free ring |
| fq_rd_idx | output | IDXW | Engine read index of the free ring |
| dq_base | input | 32 | Done ring base address |
| dq_size | input | IDXW | Done ring entries |
| dq_wr_idx | output | IDXW | Engine write index of the done ring |
| starve | output | 1 | Free ring empty while a buffer is needed |

## Verification
The bench targets the buffer boundaries. In one case a packet ends exactly when a buffer fills. In another, a small first buffer is followed by large ones. A design with the full test off by one word, or one that tests end of packet after fullness, would fetch an extra empty buffer or build a chain one link longer than expected. The threshold case checks that the segment's last descriptor carries a null pointer and the last-buffer flag, and that the next segment gets a new head. A design that keeps chaining across segments would leave a dangling pointer in memory. Both rings are driven through wrap-around, and the free ring is drained so the engine has to stall. A wrong modulo step or an empty test missed by one would read a stale entry or overrun the host.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_FETCH, S_FQA, S_FQB, S_PD0, S_PD1, S_PD2,
      S_GETW, S_WRW, S_DQ0, S_DQ1
   } rx_state_t;

   localparam logic [1:0] POL_LARGE   = 2'd0;
   localparam logic [1:0] POL_SMALL   = 2'd1;
   localparam logic [1:0] POL_SMALL1  = 2'd2;

   localparam int ST_EOP_BIT  = 16;
   localparam int ST_LAST_BIT = 17;
   localparam int DN_EOP_BIT  = 8;
endpackage

// File: rtl/rxdma_ring_ptr.sv
module rxdma_ring_ptr #(
   parameter int IDXW         = 8,
   parameter bit NATURAL_WRAP = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv,
   input  logic [IDXW-1:0] size,
   output logic [IDXW-1:0] idx
);
   logic [IDXW-1:0] nxt;

   generate
      if (NATURAL_WRAP) begin : g_nat
         logic [IDXW-1:0] size_unused;
         assign size_unused = size;
         assign nxt = idx + 1'b1;
      end else begin : g_cmp
         assign nxt = (idx == size - 1'b1) ? '0 : idx + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   idx <= '0;
      else if (adv) idx <= nxt;
   end
endmodule

// File: rtl/rxdma_size_sel.sv
module rxdma_size_sel
   import rxdma_pkg::*;
#(
   parameter int SZW = 16
) (
   input  logic [1:0]     mode,
   input  logic           first_buf,
   input  logic [SZW-1:0] small_size,
   input  logic [SZW-1:0] large_size,
   output logic [SZW-1:0] buf_size
);
   always_comb begin
      unique case (mode)
         POL_SMALL:  buf_size = small_size;
         POL_SMALL1: buf_size = first_buf ? small_size : large_size;
         default:    buf_size = large_size;
      endcase
   end
endmodule

// File: rtl/rxdma_chain_engine.sv
module rxdma_chain_engine
   import rxdma_pkg::*;
#(
   parameter int NCH       = 4,
   parameter int CHW       = (NCH > 1) ? $clog2(NCH) : 1,
   parameter int IDXW      = 8,
   parameter int SZW       = 16,
   parameter bit RING_POW2 = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_req,
   input  logic [CHW-1:0]    fifo_ch,
   input  logic [31:0]       fifo_data,
   input  logic [2:0]        fifo_nbytes,
   input  logic              fifo_eop,
   output logic              fifo_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [31:0]       mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   input  logic [2*NCH-1:0]  cfg_mode,
   input  logic [3*NCH-1:0]  cfg_thr,
   input  logic [SZW-1:0]    small_size,
   input  logic [SZW-1:0]    large_size,
   input  logic [31:0]       fq_base,
   input  logic [IDXW-1:0]   fq_size,
   input  logic [IDXW-1:0]   fq_wr_idx,
   output logic [IDXW-1:0]   fq_rd_idx,
   input  logic [31:0]       dq_base,
   input  logic [IDXW-1:0]   dq_size,
   output logic [IDXW-1:0]   dq_wr_idx,
   output logic              starve
);
   localparam int STW = 32 - 18;

   generate
      if (NCH < 1)                 begin : g_bad_nch  $error("NCH must be at least 1"); end
      if (IDXW < 1 || IDXW > 16)   begin : g_bad_idx  $error("IDXW out of range"); end
      if (SZW < 3 || SZW > 16)     begin : g_bad_szw  $error("SZW must fit the 16-bit count field"); end
   endgenerate

   rx_state_t      state;
   logic           pkt_act, pkt_first, fin, fin_eop;
   logic [CHW-1:0] act_ch;
   logic [2:0]     seg_n;
   logic [31:0]    seg_head, cur_buf, cur_desc, nbuf;
   logic [31:0]    wd_addr, wd_buf, wd_next, wd_stat;
   logic [SZW-1:0] cur_size, off, cnt, sel_size;
   logic [31:0]    wdata_r;
   logic [2:0]     nb_r;
   logic           eop_r;

   logic [1:0]     ch_mode;
   logic [2:0]     ch_thr;
   logic [31:0]    fq_addr, dq_addr;
   logic           fq_empty, fq_adv, dq_adv;
   logic [SZW-1:0] off_n, cnt_n;
   logic           full;
   logic [3:0]     seg_next;

   assign ch_mode  = cfg_mode[act_ch*2 +: 2];
   assign ch_thr   = cfg_thr[act_ch*3 +: 3];
   assign fq_addr  = fq_base + (32'(fq_rd_idx) << 3);
   assign dq_addr  = dq_base + (32'(dq_wr_idx) << 3);
   assign fq_empty = (fq_rd_idx == fq_wr_idx);
   assign fq_adv   = (state == S_FQB) && mem_ack;
   assign dq_adv   = (state == S_DQ1) && mem_ack;
   assign off_n    = off + SZW'(4);
   assign cnt_n    = cnt + SZW'(nb_r);
   assign full     = (off_n >= cur_size);
   assign seg_next = {1'b0, seg_n} + 4'd1;

   rxdma_size_sel #(.SZW(SZW)) u_size (
      .mode(ch_mode), .first_buf(pkt_first),
      .small_size(small_size), .large_size(large_size), .buf_size(sel_size)
   );

   rxdma_ring_ptr #(.IDXW(IDXW), .NATURAL_WRAP(RING_POW2)) u_fq_ptr (
      .clk(clk), .rst_n(rst_n), .adv(fq_adv), .size(fq_size), .idx(fq_rd_idx)
   );

   rxdma_ring_ptr #(.IDXW(IDXW), .NATURAL_WRAP(RING_POW2)) u_dq_ptr (
      .clk(clk), .rst_n(rst_n), .adv(dq_adv), .size(dq_size), .idx(dq_wr_idx)
   );

   // bus side decode
   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b1;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (state)
         S_FQA: begin mem_we = 1'b0; mem_addr = fq_addr; end
         S_FQB: begin mem_we = 1'b0; mem_addr = fq_addr + 32'd4; end
         S_PD0: begin mem_addr = wd_addr;          mem_wdata = wd_buf;  end
         S_PD1: begin mem_addr = wd_addr + 32'd4;  mem_wdata = wd_next; end
         S_PD2: begin mem_addr = wd_addr + 32'd8;  mem_wdata = wd_stat; end
         S_WRW: begin mem_addr = cur_buf + 32'(off); mem_wdata = wdata_r; end
         S_DQ0: begin mem_addr = dq_addr;          mem_wdata = seg_head; end
         S_DQ1: begin
            mem_addr  = dq_addr + 32'd4;
            mem_wdata = 32'(seg_n);
            mem_wdata[DN_EOP_BIT] = fin_eop;
         end
         default: begin mem_req = 1'b0; mem_we = 1'b0; end
      endcase
   end

   assign fifo_ready = (state == S_GETW);
   assign starve     = (state == S_FETCH) && fq_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         pkt_act   <= 1'b0;
         pkt_first <= 1'b0;
         fin       <= 1'b0;
         fin_eop   <= 1'b0;
         act_ch    <= '0;
         seg_n     <= '0;
         seg_head  <= '0;
         cur_buf   <= '0;
         cur_desc  <= '0;
         nbuf      <= '0;
         cur_size  <= '0;
         off       <= '0;
         cnt       <= '0;
         wd_addr   <= '0;
         wd_buf    <= '0;
         wd_next   <= '0;
         wd_stat   <= '0;
         wdata_r   <= '0;
         nb_r      <= '0;
         eop_r     <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (fifo_req) begin
               if (!pkt_act) begin
                  act_ch    <= fifo_ch;
                  pkt_act   <= 1'b1;
                  pkt_first <= 1'b1;
               end
               state <= S_FETCH;
            end
            S_FETCH: if (!fq_empty) state <= S_FQA;
            S_FQA: if (mem_ack) begin
               nbuf  <= mem_rdata;
               state <= S_FQB;
            end
            S_FQB: if (mem_ack) begin
               cur_buf  <= nbuf;
               cur_desc <= mem_rdata;
               wd_next  <= mem_rdata;
               cur_size <= sel_size;
               off      <= '0;
               cnt      <= '0;
               fin      <= 1'b0;
               if (seg_n == 3'd0) begin
                  seg_head <= mem_rdata;
                  state    <= S_GETW;
               end else begin
                  state    <= S_PD0;
               end
            end
            S_PD0: if (mem_ack) state <= S_PD1;
            S_PD1: if (mem_ack) state <= S_PD2;
            S_PD2: if (mem_ack) state <= fin ? S_DQ0 : S_GETW;
            S_GETW: if (fifo_req) begin
               wdata_r <= fifo_data;
               nb_r    <= fifo_nbytes;
               eop_r   <= fifo_eop;
               state   <= S_WRW;
            end
            S_WRW: if (mem_ack) begin
               off <= off_n;
               cnt <= cnt_n;
               wd_addr <= cur_desc;
               wd_buf  <= cur_buf;
               if (eop_r || (full && (seg_next >= {1'b0, ch_thr}))) begin
                  wd_next   <= '0;
                  wd_stat   <= {STW'(0), 1'b1, eop_r, 16'(cnt_n)};
                  seg_n     <= seg_next[2:0];
                  fin       <= 1'b1;
                  fin_eop   <= eop_r;
                  pkt_first <= 1'b0;
                  state     <= S_PD0;
               end else if (full) begin
                  wd_stat   <= {STW'(0), 2'b00, 16'(cnt_n)};
                  seg_n     <= seg_next[2:0];
                  pkt_first <= 1'b0;
                  state     <= S_FETCH;
               end else begin
                  state     <= S_GETW;
               end
            end
            S_DQ0: if (mem_ack) state <= S_DQ1;
            S_DQ1: if (mem_ack) begin
               seg_n <= '0;
               if (fin_eop) pkt_act <= 1'b0;
               state <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxdma_chain_chk.sv
module rxdma_chain_chk #(
   parameter int IDXW = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            fifo_ready,
   input logic            starve,
   input logic            mem_req,
   input logic            mem_we,
   input logic [31:0]     mem_addr,
   input logic            mem_ack,
   input logic [IDXW-1:0] fq_rd_idx,
   input logic [IDXW-1:0] dq_wr_idx
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R10
   AST_STARVE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      starve |-> !fifo_ready); // R9
   AST_FQ_ADV_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (fq_rd_idx != $past(fq_rd_idx)) |-> $past(mem_req && mem_ack && !mem_we)); // R2
   AST_DQ_ADV_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_wr_idx != $past(dq_wr_idx)) |-> $past(mem_req && mem_ack && mem_we)); // R7
endmodule

bind rxdma_chain_engine rxdma_chain_chk #(.IDXW(IDXW)) u_chain_chk (
   .clk(clk), .rst_n(rst_n), .fifo_ready(fifo_ready), .starve(starve),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
   .fq_rd_idx(fq_rd_idx), .dq_wr_idx(dq_wr_idx)
);

// File: tb/test_rxdma_chain_engine.sv
module test_rxdma_chain_engine;
   localparam int NCH = 4, CHW = 2, IDXW = 8, SZW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic            fifo_req = 1'b0, fifo_eop = 1'b0;
   logic [CHW-1:0]  fifo_ch = '0;
   logic [31:0]     fifo_data = '0;
   logic [2:0]      fifo_nbytes = 3'd4;
   logic            fifo_ready, mem_req, mem_we, mem_ack, starve;
   logic [31:0]     mem_addr, mem_wdata, mem_rdata;
   logic [2*NCH-1:0] cfg_mode = 8'b01_01_10_00;
   logic [3*NCH-1:0] cfg_thr  = {3'd7, 3'd2, 3'd7, 3'd7};
   logic [SZW-1:0]  small_size = 16'd8, large_size = 16'd16;
   logic [31:0]     fq_base = 32'h0, dq_base = 32'h100;
   logic [IDXW-1:0] fq_size = 8'd8, dq_size = 8'd4, fq_wr_idx = 8'd7;
   logic [IDXW-1:0] fq_rd_idx, dq_wr_idx;

   int n_chk = 0, n_bad = 0, n_misalign = 0;
   logic [31:0] mem [0:4095];

   rxdma_chain_engine #(.NCH(NCH), .IDXW(IDXW), .SZW(SZW)) i_rxdma_chain_engine (
      .clk(clk), .rst_n(rst_n), .fifo_req(fifo_req), .fifo_ch(fifo_ch),
      .fifo_data(fifo_data), .fifo_nbytes(fifo_nbytes), .fifo_eop(fifo_eop),
      .fifo_ready(fifo_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(mem_ack), .cfg_mode(cfg_mode), .cfg_thr(cfg_thr),
      .small_size(small_size), .large_size(large_size), .fq_base(fq_base),
      .fq_size(fq_size), .fq_wr_idx(fq_wr_idx), .fq_rd_idx(fq_rd_idx),
      .dq_base(dq_base), .dq_size(dq_size), .dq_wr_idx(dq_wr_idx), .starve(starve)
   );

   // memory responder: one access per two cycles
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
      end else if (mem_req && !mem_ack) begin
         if (mem_addr[1:0] != 2'b00) n_misalign <= n_misalign + 1;
         if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
         else        mem_rdata <= mem[mem_addr[13:2]];
         mem_ack <= 1'b1;
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] rd(input logic [31:0] a);
      return mem[a[13:2]];
   endfunction

   // called at a negedge; returns at the negedge after the word is taken
   task automatic push(input logic [CHW-1:0] ch, input logic [31:0] d,
                       input logic [2:0] nb, input logic eop);
      fifo_req = 1'b1; fifo_ch = ch; fifo_data = d; fifo_nbytes = nb; fifo_eop = eop;
      while (!fifo_ready) @(negedge clk);
      @(negedge clk);
      fifo_req = 1'b0; fifo_eop = 1'b0;
   endtask

   task automatic wait_dq(input logic [IDXW-1:0] exp);
      for (int i = 0; i < 1000 && dq_wr_idx != exp; i++) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 fifo_ready", 32'(fifo_ready), 0);
      chk("R1 mem_req",    32'(mem_req), 0);
      chk("R1 starve",     32'(starve), 0);
      chk("R1 fq_rd_idx",  32'(fq_rd_idx), 0);
      chk("R1 dq_wr_idx",  32'(dq_wr_idx), 0);
   endtask

   // ch0 large only, 10 bytes in one buffer
   task automatic t_single;
      push(2'd0, 32'hA000_0000, 3'd4, 1'b0);
      push(2'd0, 32'hA000_0001, 3'd4, 1'b0);
      push(2'd0, 32'hA000_0002, 3'd2, 1'b1);
      wait_dq(8'd1);
      chk("R2 fq_rd_idx", 32'(fq_rd_idx), 1);
      for (int k = 0; k < 3; k++) chk("R3 data", rd(32'h1000 + 4*k), 32'hA000_0000 + k);
      chk("R6 desc buf",  rd(32'h800), 32'h1000);
      chk("R6 desc next", rd(32'h804), 32'h0);
      chk("R6 desc stat", rd(32'h808), 32'h0003_000A);
      chk("R7 done head", rd(32'h100), 32'h800);
      chk("R7 done stat", rd(32'h104), 32'h101);
   endtask

   // ch1 small first then large, 28 bytes over three buffers
   task automatic t_small_first;
      for (int k = 0; k < 7; k++) push(2'd1, 32'hB000_0000 + k, 3'd4, k == 6);
      wait_dq(8'd2);
      chk("R2 fq_rd_idx", 32'(fq_rd_idx), 4);
      chk("R3 data b0", rd(32'h1104), 32'hB000_0001);
      chk("R4 data b1", rd(32'h120C), 32'hB000_0005);
      chk("R4 data b2", rd(32'h1300), 32'hB000_0006);
      chk("R5 d1 buf",  rd(32'h810), 32'h1100);
      chk("R5 d1 next", rd(32'h814), 32'h820);
      chk("R4 d1 stat small", rd(32'h818), 32'd8);
      chk("R5 d2 next", rd(32'h824), 32'h830);
      chk("R4 d2 stat large", rd(32'h828), 32'd16);
      chk("R6 d3 next", rd(32'h834), 32'h0);
      chk("R6 d3 stat", rd(32'h838), 32'h0003_0004);
      chk("R7 done head", rd(32'h108), 32'h810);
      chk("R7 done stat", rd(32'h10C), 32'h103);
   endtask

   // ch2 small only, threshold 2, 24 bytes
   task automatic t_threshold;
      for (int k = 0; k < 6; k++) push(2'd2, 32'hC000_0000 + k, 3'd4, k == 5);
      wait_dq(8'd0);
      chk("R7 dq wrap", 32'(dq_wr_idx), 0);
      chk("R11 d4 stat small", rd(32'h848), 32'd8);
      chk("R5 d4 next", rd(32'h844), 32'h850);
      chk("R8 d5 next", rd(32'h854), 32'h0);
      chk("R8 d5 stat", rd(32'h858), 32'h0002_0008);
      chk("R8 seg1 head", rd(32'h110), 32'h840);
      chk("R8 seg1 stat", rd(32'h114), 32'h002);
      chk("R8 seg2 head", rd(32'h118), 32'h860);
      chk("R8 seg2 stat", rd(32'h11C), 32'h101);
      chk("R6 d6 stat", rd(32'h868), 32'h0003_0008);
      chk("R3 data", rd(32'h1604), 32'hC000_0005);
   endtask

   // free ring empty: stall until the host advances its index
   task automatic t_starve;
      fork
         push(2'd3, 32'hD000_0007, 3'd3, 1'b1);
         begin
            repeat (20) @(negedge clk);
            chk("R9 starve high", 32'(starve), 1);
            chk("R9 ready low",   32'(fifo_ready), 0);
            chk("R9 no fetch",    32'(fq_rd_idx), 7);
            fq_wr_idx = 8'd0;
         end
      join
      wait_dq(8'd1);
      chk("R9 starve clear", 32'(starve), 0);
      chk("R2 fq wrap", 32'(fq_rd_idx), 0);
      chk("R3 data", rd(32'h1700), 32'hD000_0007);
      chk("R6 d7 stat", rd(32'h878), 32'h0003_0003);
      chk("R7 done head", rd(32'h100), 32'h870);
      chk("R10 misaligned", 32'(n_misalign), 0);
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = '0;
      for (int i = 0; i < 8; i++) begin
         mem[2*i]     = 32'h1000 + 32'h100 * i;
         mem[2*i + 1] = 32'h800 + 32'h10 * i;
      end
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_single();
      t_small_first();
      t_threshold();
      t_starve();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule